// File: doc/BRIEF.md
# Descriptor Ring Write-Back Controller

This block returns finished 16-byte descriptors to a circular ring in host memory. Completed descriptors are counted in a small local queue of depth `QDEPTH`. The controller decides how many of them to send back in one burst. It raises a single DMA write request carrying a target address and a byte count, and holds the request until the DMA engine reports completion. It then moves the ring head forward. Only one burst is ever in flight.

Three sources can start a burst:
- a push-driven threshold trigger;
- a forced input, used for timer expiry or an empty ring;
- an automatic follow-up burst after a burst that was cut short at the end of the ring.

The burst size is limited so that it never runs past the end of the ring. It can also be rounded down to a power-of-two block so that writes stay aligned.

Top module: `desc_wb_ctrl`

## Requirements
- R1: After reset `dma_req`, `wb_done` and `used_full` are 0, and `head` and `used_count` are 0.
- R2: Each `used_push` taken while `used_full` is 0 raises `used_count` by one. `used_full` is 1 exactly when `used_count` equals `QDEPTH`. A push made while full is dropped, and `used_count` never exceeds `QDEPTH`.
- R3: An issued burst drives `dma_addr` = `ring_base` + `head`×16 and `dma_bytes` = (descriptor count)×16, both held steady while `dma_req` is 1.
- R4: When the burst is not clipped and its alignment mask is nonzero, the count is `used_count` AND NOT mask (rounded down to a multiple of mask+1).
- R5: The ring length in descriptors is `ring_len_bytes` divided by 16. If `head` + `used_count` exceeds that length, the count becomes length − `head`. One cycle after that burst completes, a follow-up burst is evaluated with the same mask, starting from the wrapped head.
- R6: A burst request is ignored when the computed count is zero or when a burst is already outstanding. `dma_addr` and `dma_bytes` stay unchanged and `used_count` is not reduced.
- R7: A `dma_done` while `dma_req` is 1 clears `dma_req` on the next edge. It advances `head` by the burst count modulo the ring length, and pulses `wb_done` for exactly one cycle. `head` changes at no other time.
- R8: `used_count` drops by the burst count on the edge where the burst is issued. A push on that same edge is also counted.
- R9: With `wb_thresh` = 0, every accepted push is followed one cycle later by an unaligned (mask 0) burst request.
- R10: With `wb_thresh` ≠ 0, one cycle after an accepted push a request with mask `blk_mask` is made if `wb_thresh` ≥ `used_count`. Otherwise no request is made.
- R11: `force_wb` requests a burst with mask 0 on the edge where it is sampled, and takes priority over the threshold trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W | Ring base address in host memory |
| ring_len_bytes | input | LEN_W | Ring length in bytes (multiple of 16) |
| wb_thresh | input | CNT_W | Write-back threshold; 0 means write back after every descriptor |
| blk_mask | input | CNT_W | Alignment mask in descriptors (block size − 1) |
| used_push | input | 1 | One descriptor has completed and joins the used queue |
| force_wb | input | 1 | Request an unaligned write-back now |
| dma_done | input | 1 | DMA engine finished the outstanding write |
| used_full | output | 1 | Used queue is at capacity; pushes are refused |
| used_count | output | CNT_W | Descriptors waiting for write-back |
| head | output | IDX_W | Ring head index in descriptors |
| dma_req | output | 1 | DMA write request, high while outstanding |
| dma_addr | output | ADDR_W | Write target address |
| dma_bytes | output | CNT_W+4 | Write length in bytes |
| wb_done | output | 1 | One-cycle pulse after each completed burst |

## Verification
The bench drives the head to index 5 and then forces a six-descriptor burst into an eight-entry ring. A design that ignored the wrap would write past the end of the ring. A design that dropped the follow-up would leave three descriptors stranded with no request. It checks that a request made while a burst is outstanding leaves the address and count untouched; a design that re-issued would corrupt the transfer in flight. Alignment with a mask of 7 must hold back every count from one to seven. A push made while the queue is full must be refused; a faulty counter would wrap or overflow. A threshold below the used count must produce no request at all.

// File: rtl/desc_wb_pkg.sv
package desc_wb_pkg;
  // log2 of the descriptor size in bytes
  localparam int DESC_LOG2 = 4;

  // source of the request being evaluated this cycle
  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_FORCE  = 2'd1,
    SRC_FOLLOW = 2'd2,
    SRC_THRESH = 2'd3
  } wb_src_e;
endpackage

// File: rtl/wbc_used_ctr.sv
module wbc_used_ctr #(
  parameter int QDEPTH = 8,
  parameter int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             dec_v,
  input  logic [CNT_W-1:0] dec_n,
  output logic             push_acc,
  output logic             full,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(QDEPTH);

  logic [CNT_W-1:0] dec_amt;

  assign full     = (count == DEPTH_C);
  assign push_acc = push && !full;
  assign dec_amt  = dec_v ? dec_n : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(push_acc) - dec_amt;
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);

  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !dec_v) |=> (count == DEPTH_C));
endmodule

// File: rtl/wbc_burst_calc.sv
module wbc_burst_calc #(
  parameter int IDX_W = 12,
  parameter int CNT_W = 4
) (
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] ring_len,
  input  logic [CNT_W-1:0] used,
  input  logic [CNT_W-1:0] mask,
  output logic [CNT_W-1:0] n,
  output logic             clipped
);
  localparam int SW = IDX_W + 1;

  logic [SW-1:0]    reach;
  logic [IDX_W-1:0] room;

  assign reach = {1'b0, head} + SW'(used);
  assign room  = ring_len - head;

  always_comb begin
    clipped = 1'b0;
    n       = used;
    if (reach > {1'b0, ring_len}) begin
      clipped = 1'b1;
      n       = CNT_W'(room);
    end else if (mask != '0) begin
      n = used & ~mask;
    end
  end
endmodule

// File: rtl/wbc_trigger.sv
module wbc_trigger
  import desc_wb_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_acc,
  input  logic [CNT_W-1:0] thresh,
  input  logic [CNT_W-1:0] blk_mask,
  input  logic [CNT_W-1:0] used_cnt,
  input  logic             force_wb,
  input  logic             follow_pend,
  input  logic [CNT_W-1:0] follow_mask,
  output logic             req_v,
  output logic [CNT_W-1:0] req_mask,
  output wb_src_e          req_src
);
  logic thr_pend;
  logic thr_fire;

  always_ff @(posedge clk) begin
    if (rst) thr_pend <= 1'b0;
    else     thr_pend <= push_acc;
  end

  assign thr_fire = thr_pend && ((thresh == '0) || (thresh >= used_cnt));

  always_comb begin
    req_src  = SRC_NONE;
    req_mask = '0;
    if (force_wb) begin
      req_src = SRC_FORCE;
    end else if (follow_pend) begin
      req_src  = SRC_FOLLOW;
      req_mask = follow_mask;
    end else if (thr_fire) begin
      req_src  = SRC_THRESH;
      req_mask = (thresh == '0) ? '0 : blk_mask;
    end
  end

  assign req_v = (req_src != SRC_NONE);

  // R11
  force_mask_chk: assert property (@(posedge clk) disable iff (rst)
    force_wb |-> (req_mask == '0));

  // R9
  zero_thresh_chk: assert property (@(posedge clk) disable iff (rst)
    (push_acc && thresh == '0 && $stable(thresh)) |=> req_v);
endmodule

// File: rtl/wbc_head_track.sv
module wbc_head_track #(
  parameter int IDX_W = 12,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [CNT_W-1:0] step,
  input  logic [IDX_W-1:0] ring_len,
  output logic [IDX_W-1:0] head
);
  localparam int SW = IDX_W + 1;

  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;

  assign sum     = {1'b0, head} + SW'(step);
  assign wrapped = (sum >= {1'b0, ring_len}) ? (sum - {1'b0, ring_len}) : sum;

  always_ff @(posedge clk) begin
    if (rst)          head <= '0;
    else if (advance) head <= wrapped[IDX_W-1:0];
  end

  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(head));
endmodule

// File: rtl/desc_wb_ctrl.sv
module desc_wb_ctrl
  import desc_wb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int QDEPTH = 8,
  parameter int CNT_W  = $clog2(QDEPTH + 1),
  parameter int IDX_W  = LEN_W - DESC_LOG2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         ring_base,
  input  logic [LEN_W-1:0]          ring_len_bytes,
  input  logic [CNT_W-1:0]          wb_thresh,
  input  logic [CNT_W-1:0]          blk_mask,
  input  logic                      used_push,
  input  logic                      force_wb,
  input  logic                      dma_done,
  output logic                      used_full,
  output logic [CNT_W-1:0]          used_count,
  output logic [IDX_W-1:0]          head,
  output logic                      dma_req,
  output logic [ADDR_W-1:0]         dma_addr,
  output logic [CNT_W+DESC_LOG2-1:0] dma_bytes,
  output logic                      wb_done
);
  localparam int BYTES_W = CNT_W + DESC_LOG2;

  logic [IDX_W-1:0] ring_len;
  logic             push_acc;
  logic             req_v;
  logic [CNT_W-1:0] req_mask;
  wb_src_e          req_src;
  logic [CNT_W-1:0] burst_n;
  logic             burst_clip;
  logic             issue;
  logic             finish;

  logic             outstanding;
  logic [CNT_W-1:0] inflight_n;
  logic             more_due;
  logic [CNT_W-1:0] saved_mask;
  logic             follow_pend;

  assign ring_len = ring_len_bytes[LEN_W-1:DESC_LOG2];
  assign issue    = req_v && !outstanding && (burst_n != '0);
  assign finish   = outstanding && dma_done;

  wbc_used_ctr #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) u_used (
    .clk      (clk),
    .rst      (rst),
    .push     (used_push),
    .dec_v    (issue),
    .dec_n    (burst_n),
    .push_acc (push_acc),
    .full     (used_full),
    .count    (used_count)
  );

  wbc_trigger #(.CNT_W(CNT_W)) u_trig (
    .clk         (clk),
    .rst         (rst),
    .push_acc    (push_acc),
    .thresh      (wb_thresh),
    .blk_mask    (blk_mask),
    .used_cnt    (used_count),
    .force_wb    (force_wb),
    .follow_pend (follow_pend),
    .follow_mask (saved_mask),
    .req_v       (req_v),
    .req_mask    (req_mask),
    .req_src     (req_src)
  );

  wbc_burst_calc #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_calc (
    .head     (head),
    .ring_len (ring_len),
    .used     (used_count),
    .mask     (req_mask),
    .n        (burst_n),
    .clipped  (burst_clip)
  );

  wbc_head_track #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_head (
    .clk      (clk),
    .rst      (rst),
    .advance  (finish),
    .step     (inflight_n),
    .ring_len (ring_len),
    .head     (head)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      dma_addr    <= '0;
      dma_bytes   <= '0;
      inflight_n  <= '0;
      more_due    <= 1'b0;
      saved_mask  <= '0;
      follow_pend <= 1'b0;
      wb_done     <= 1'b0;
    end else begin
      wb_done     <= 1'b0;
      follow_pend <= 1'b0;
      if (finish) begin
        outstanding <= 1'b0;
        wb_done     <= 1'b1;
        follow_pend <= more_due;
        more_due    <= 1'b0;
      end else if (issue) begin
        outstanding <= 1'b1;
        dma_addr    <= ring_base + ADDR_W'({head, {DESC_LOG2{1'b0}}});
        dma_bytes   <= BYTES_W'({burst_n, {DESC_LOG2{1'b0}}});
        inflight_n  <= burst_n;
        more_due    <= burst_clip;
        saved_mask  <= req_mask;
      end
    end
  end

  assign dma_req = outstanding;

  // R6
  hold_request_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_req && !dma_done) |=> (dma_req && $stable(dma_addr) && $stable(dma_bytes)));

  // R3
  nonzero_bytes_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (dma_bytes != '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_done |=> !wb_done);

  // R7
  done_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_done) |-> $fell(dma_req));

  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> (({1'b0, head} + (IDX_W+1)'(burst_n)) <= {1'b0, ring_len}));
endmodule

// File: tb/tb_desc_wb_ctrl.sv
module tb_desc_wb_ctrl;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int QDEPTH = 8;
  localparam int CNT_W  = $clog2(QDEPTH + 1);
  localparam int IDX_W  = LEN_W - 4;
  localparam logic [ADDR_W-1:0] BASE = 32'h1000_0000;

  logic clk = 1'b0;
  logic rst;
  logic [ADDR_W-1:0] ring_base;
  logic [LEN_W-1:0]  ring_len_bytes;
  logic [CNT_W-1:0]  wb_thresh;
  logic [CNT_W-1:0]  blk_mask;
  logic used_push, force_wb, dma_done;
  logic used_full;
  logic [CNT_W-1:0] used_count;
  logic [IDX_W-1:0] head;
  logic dma_req;
  logic [ADDR_W-1:0] dma_addr;
  logic [CNT_W+3:0] dma_bytes;
  logic wb_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  desc_wb_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .QDEPTH(QDEPTH)) dut (
    .clk(clk), .rst(rst), .ring_base(ring_base), .ring_len_bytes(ring_len_bytes),
    .wb_thresh(wb_thresh), .blk_mask(blk_mask), .used_push(used_push),
    .force_wb(force_wb), .dma_done(dma_done), .used_full(used_full),
    .used_count(used_count), .head(head), .dma_req(dma_req), .dma_addr(dma_addr),
    .dma_bytes(dma_bytes), .wb_done(wb_done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_one();
    used_push = 1'b1; tick(); used_push = 1'b0;
  endtask

  task automatic force_one();
    force_wb = 1'b1; tick(); force_wb = 1'b0;
  endtask

  task automatic complete(input int exp_head);
    dma_done = 1'b1; tick(); dma_done = 1'b0;
    chk("R7", "dma_req after done", dma_req, 0);
    chk("R7", "wb_done pulse", wb_done, 1);
    chk("R7", "head", head, exp_head);
    tick();
    chk("R7", "wb_done drop", wb_done, 0);
  endtask

  task automatic t_reset();
    chk("R1", "dma_req", dma_req, 0);
    chk("R1", "wb_done", wb_done, 0);
    chk("R1", "used_full", used_full, 0);
    chk("R1", "head", head, 0);
    chk("R1", "used_count", used_count, 0);
  endtask

  task automatic t_fill_aligned();
    wb_thresh = 15; blk_mask = 7;
    for (int i = 0; i < 7; i++) begin
      push_one(); tick();
      chk("R4", "no burst below block", dma_req, 0);
    end
    chk("R2", "count 7", used_count, 7);
    push_one();
    chk("R2", "count 8", used_count, 8);
    chk("R2", "full", used_full, 1);
    used_push = 1'b1; tick(); used_push = 1'b0;
    chk("R4", "full block issued", dma_req, 1);
    chk("R3", "addr", dma_addr, BASE);
    chk("R3", "bytes", dma_bytes, 128);
    chk("R2", "push while full dropped", used_count, 0);
    chk("R8", "full clear", used_full, 0);
    complete(0);
  endtask

  task automatic t_thresh_zero();
    wb_thresh = 0; blk_mask = 7;
    push_one(); tick();
    chk("R9", "req", dma_req, 1);
    chk("R9", "addr", dma_addr, BASE);
    chk("R9", "bytes", dma_bytes, 16);
    chk("R8", "count", used_count, 0);
    complete(1);
  endtask

  task automatic t_busy_ignore();
    wb_thresh = 1; blk_mask = 0;
    push_one(); tick();
    chk("R10", "req", dma_req, 1);
    chk("R3", "addr", dma_addr, BASE + 16);
    push_one(); push_one(); tick();
    force_one();
    chk("R6", "still req", dma_req, 1);
    chk("R6", "addr kept", dma_addr, BASE + 16);
    chk("R6", "bytes kept", dma_bytes, 16);
    chk("R6", "count kept", used_count, 2);
    complete(2);
    push_one(); tick();
    chk("R10", "above thresh no req", dma_req, 0);
    chk("R10", "count", used_count, 3);
  endtask

  task automatic t_force_and_wrap();
    force_one();
    chk("R11", "req", dma_req, 1);
    chk("R11", "addr", dma_addr, BASE + 32);
    chk("R11", "bytes", dma_bytes, 48);
    chk("R8", "count", used_count, 0);
    complete(5);
    wb_thresh = 2; blk_mask = 7;
    for (int i = 0; i < 6; i++) begin
      push_one(); tick();
    end
    chk("R10", "no req", dma_req, 0);
    chk("R2", "count 6", used_count, 6);
    force_one();
    chk("R5", "clipped req", dma_req, 1);
    chk("R5", "addr", dma_addr, BASE + 80);
    chk("R5", "clipped bytes", dma_bytes, 48);
    chk("R8", "remaining", used_count, 3);
    complete(0);
    chk("R5", "follow-up req", dma_req, 1);
    chk("R5", "follow-up addr", dma_addr, BASE);
    chk("R5", "follow-up bytes", dma_bytes, 48);
    chk("R8", "count", used_count, 0);
    complete(3);
  endtask

  task automatic t_pair_align();
    wb_thresh = 15; blk_mask = 1;
    push_one(); tick();
    chk("R4", "odd held", dma_req, 0);
    chk("R4", "count", used_count, 1);
    push_one(); tick();
    chk("R4", "pair req", dma_req, 1);
    chk("R4", "addr", dma_addr, BASE + 48);
    chk("R4", "bytes", dma_bytes, 32);
    complete(5);
  endtask

  initial begin
    rst = 1'b1; used_push = 1'b0; force_wb = 1'b0; dma_done = 1'b0;
    ring_base = BASE; ring_len_bytes = 16'd128; wb_thresh = 15; blk_mask = 7;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_fill_aligned();
    t_thresh_zero();
    t_busy_ignore();
    t_force_and_wrap();
    t_pair_align();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule